// File: doc/BRIEF.md
# PWM Carrier Chopper

This block takes one reference PWM waveform per channel and, while that reference is active, replaces its flat high phase with a high-frequency pulse train. The pulse train is suitable for driving a gate transformer. Each active phase begins with a wide start pulse. A carrier of programmable period and duty then follows, and it is restarted in phase when the start pulse ends. As a result, every active phase has the same shape. When the reference drops, the output falls in the same cycle, even in the middle of a carrier period.

The channels share one configuration: a frequency code, a duty code and a start-width code. All timing runs from the undivided clock. The configuration is sampled only while every channel has chopping switched off. While any channel is chopping, the configuration is held and changes on the configuration pins have no effect. A channel with chopping off passes its reference straight to its output.

There is no streaming data path. All pins are plain level signals with no valid/ready handshake, so there is no back-pressure to manage.

Top module: `chop_carrier`

## Requirements
- R1: During and after reset, with every reference low, every output is 0. Internal timing restarts from the beginning of a start pulse.
- R2: A channel whose enable bit is 0 drives its output equal to its reference in every cycle.
- R3: In an enabled channel, the output is 1 for the first (cfg_start+1)×16 cycles in which the reference is high. Cycle 0 is the first high cycle.
- R4: After the start pulse, the carrier repeats with a period of 16×(cfg_freq+1) cycles. Its first period begins in the cycle right after the start pulse ends.
- R5: Within each carrier period, the output is 1 for the first cfg_duty×2×(cfg_freq+1) cycles and 0 for the rest of that period.
- R6: With cfg_duty = 0, an enabled channel emits only the start pulse. The output is then 0 for the rest of the active phase.
- R7: When the reference of an enabled channel is 0, that channel's output is 0 in the same cycle. The next high phase repeats the full shape from its start pulse.
- R8: The configuration is captured on a clock edge only when all enable bits are 0. Values presented while any enable bit is 1 have no effect on any channel.
- R9: Channel i uses chop_en[i], ref_in[i] and chop_out[i] (bit i of each vector). Each channel times its own reference independently, using the shared configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| chop_en | input | NCH | Per-channel chopping enable |
| ref_in | input | NCH | Per-channel reference waveform |
| cfg_freq | input | FREQ_W | Carrier frequency code |
| cfg_duty | input | DUTY_W | Carrier duty code in eighths |
| cfg_start | input | STRT_W | Start pulse width code |
| chop_out | output | NCH | Per-channel chopped output |

## Verification
A stuck or misloaded phase counter shows up as a start pulse of the wrong length, or as a carrier edge one cycle early or late. The bench compares every cycle of every active phase with an arithmetic model, so such a fault appears at the first affected edge. That is no later than one start pulse plus one carrier period after the reference rises. A register that fails to clear between active phases, or a held configuration that leaks through, breaks the next high phase. The bench checks that phase in full.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int FREQ_W_D  = 4;
  localparam int DUTY_W_D  = 3;
  localparam int STRT_W_D  = 4;
  localparam int UNIT_LG_D = 4;

  typedef enum logic {
    PH_START = 1'b0,
    PH_CARR  = 1'b1
  } chop_phase_e;
endpackage

// File: rtl/chop_cfg_hold.sv
module chop_cfg_hold #(
  parameter int NCH    = 2,
  parameter int FREQ_W = chop_pkg::FREQ_W_D,
  parameter int DUTY_W = chop_pkg::DUTY_W_D,
  parameter int STRT_W = chop_pkg::STRT_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [STRT_W-1:0] strt_i,
  output logic [FREQ_W-1:0] freq_q,
  output logic [DUTY_W-1:0] duty_q,
  output logic [STRT_W-1:0] strt_q
);
  logic any_on;
  assign any_on = |en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      duty_q <= '0;
      strt_q <= '0;
    end else if (!any_on) begin
      freq_q <= freq_i;
      duty_q <= duty_i;
      strt_q <= strt_i;
    end
  end

  // R8: settings frozen while any channel chops
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_on |=> ($stable(freq_q) && $stable(duty_q) && $stable(strt_q)));
endmodule

// File: rtl/chop_timing.sv
module chop_timing #(
  parameter int FREQ_W  = chop_pkg::FREQ_W_D,
  parameter int DUTY_W  = chop_pkg::DUTY_W_D,
  parameter int STRT_W  = chop_pkg::STRT_W_D,
  parameter int UNIT_LG = chop_pkg::UNIT_LG_D,
  parameter int CW      = ((STRT_W > FREQ_W) ? STRT_W : FREQ_W) + UNIT_LG
) (
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [STRT_W-1:0] strt_i,
  output logic [CW-1:0]     start_last_o,
  output logic [CW-1:0]     period_last_o,
  output logic [CW-1:0]     high_len_o
);
  localparam logic [CW-1:0] UNIT_ONES = CW'((1 << UNIT_LG) - 1);
  localparam int            STEP_SH   = UNIT_LG - DUTY_W;

  logic [CW-1:0] step_len;

  always_comb begin
    start_last_o  = (CW'(strt_i) << UNIT_LG) | UNIT_ONES;
    period_last_o = (CW'(freq_i) << UNIT_LG) | UNIT_ONES;
    step_len      = (CW'(freq_i) + CW'(1)) << STEP_SH;
    high_len_o    = CW'(duty_i) * step_len;
  end

  initial begin
    a_step_fits: assert (UNIT_LG >= DUTY_W);
  end
endmodule

// File: rtl/chop_lane.sv
module chop_lane #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ref_i,
  input  logic [CW-1:0] start_last_i,
  input  logic [CW-1:0] period_last_i,
  input  logic [CW-1:0] high_len_i,
  output logic          out_o
);
  import chop_pkg::*;

  chop_phase_e phase_q;
  logic [CW-1:0] cnt_q;
  logic active, mask;

  assign active = en_i & ref_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
    end else if (!active) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_START: begin
          if (cnt_q == start_last_i) begin
            phase_q <= PH_CARR;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_CARR: begin
          if (cnt_q == period_last_i) cnt_q <= '0;
          else                        cnt_q <= cnt_q + CW'(1);
        end
        default: begin
          phase_q <= PH_START;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    mask  = (phase_q == PH_START) ? 1'b1 : (cnt_q < high_len_i);
    out_o = en_i ? (ref_i & mask) : ref_i;
  end

  // R7: each active phase begins from a fresh start pulse
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> (phase_q == PH_START && cnt_q == '0));
  // R3: start pulse hands over to carrier right after its last cycle
  p_start_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_q == PH_START && cnt_q == start_last_i)
      |=> (!active || (phase_q == PH_CARR && cnt_q == '0)));
  // R4: carrier counter wraps at the period boundary
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_q == PH_CARR && cnt_q == period_last_i)
      |=> (!active || cnt_q == '0));
  // R6: zero duty leaves no carrier pulses
  p_duty0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && phase_q == PH_CARR && high_len_i == '0) |-> !out_o);
  // R5: carrier count never leaves its period
  p_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_q == PH_CARR) |-> (cnt_q <= period_last_i));
endmodule

// File: rtl/chop_carrier.sv
module chop_carrier #(
  parameter int NCH     = 2,
  parameter int FREQ_W  = chop_pkg::FREQ_W_D,
  parameter int DUTY_W  = chop_pkg::DUTY_W_D,
  parameter int STRT_W  = chop_pkg::STRT_W_D,
  parameter int UNIT_LG = chop_pkg::UNIT_LG_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chop_en,
  input  logic [NCH-1:0]    ref_in,
  input  logic [FREQ_W-1:0] cfg_freq,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic [STRT_W-1:0] cfg_start,
  output logic [NCH-1:0]    chop_out
);
  localparam int CW = ((STRT_W > FREQ_W) ? STRT_W : FREQ_W) + UNIT_LG;

  logic [FREQ_W-1:0] freq_q;
  logic [DUTY_W-1:0] duty_q;
  logic [STRT_W-1:0] strt_q;
  logic [CW-1:0]     start_last, period_last, high_len;

  chop_cfg_hold #(.NCH(NCH), .FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .STRT_W(STRT_W))
    u_cfg (
      .clk(clk), .rst_n(rst_n), .en_i(chop_en),
      .freq_i(cfg_freq), .duty_i(cfg_duty), .strt_i(cfg_start),
      .freq_q(freq_q), .duty_q(duty_q), .strt_q(strt_q)
    );

  chop_timing #(.FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .STRT_W(STRT_W),
                .UNIT_LG(UNIT_LG), .CW(CW))
    u_tim (
      .freq_i(freq_q), .duty_i(duty_q), .strt_i(strt_q),
      .start_last_o(start_last), .period_last_o(period_last),
      .high_len_o(high_len)
    );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    chop_lane #(.CW(CW)) u_lane (
      .clk(clk), .rst_n(rst_n), .en_i(chop_en[g]), .ref_i(ref_in[g]),
      .start_last_i(start_last), .period_last_i(period_last),
      .high_len_i(high_len), .out_o(chop_out[g])
    );

    // R2: disabled channel is a plain pass-through
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chop_en[g] |-> (chop_out[g] == ref_in[g]));
    // R7: low reference gives low output on an enabled channel
    p_ref_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_en[g] && !ref_in[g]) |-> !chop_out[g]);
  end
endmodule

// File: tb/test_chop_carrier.sv
`timescale 1ns/1ps
module test_chop_carrier;
  localparam int NCH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chop_en = '0;
  logic [1:0] ref_in = '0;
  logic [3:0] cfg_freq = '0;
  logic [2:0] cfg_duty = '0;
  logic [3:0] cfg_start = '0;
  logic [1:0] chop_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  chop_carrier #(.NCH(NCH)) i_chop_carrier (
    .clk(clk), .rst_n(rst_n), .chop_en(chop_en), .ref_in(ref_in),
    .cfg_freq(cfg_freq), .cfg_duty(cfg_duty), .cfg_start(cfg_start),
    .chop_out(chop_out)
  );

  function automatic bit model(int k, int f, int d, int s);
    int sl, per;
    sl  = (s + 1) * 16;
    per = 16 * (f + 1);
    if (k < sl) return 1'b1;
    return ((k - sl) % per) < (d * 2 * (f + 1));
  endfunction

  task automatic check(bit got, bit exp, string req, int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %0b expected %0b", req, k, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(int f, int d, int s);
    chop_en   = '0;
    cfg_freq  = 4'(f);
    cfg_duty  = 3'(d);
    cfg_start = 4'(s);
    step();
  endtask

  // drive ch high for len cycles, compare against config (f,d,s)
  task automatic pulse(int ch, int len, int f, int d, int s, string req);
    ref_in[ch] = 1'b1;
    for (int k = 0; k < len; k++) begin
      #1.5;
      check(chop_out[ch], model(k, f, d, s), req, k);
      step();
    end
    ref_in[ch] = 1'b0;
    #0.5;
    check(chop_out[ch], 1'b0, "R7", len);
    step();
    step();
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    chop_en = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    check(chop_out[0], 1'b0, "R1", 0);
    check(chop_out[1], 1'b0, "R1", 0);
    rst_n = 1'b1;
    step();
    check(chop_out[0], 1'b0, "R1", 1);
    check(chop_out[1], 1'b0, "R1", 1);

    // R2: bypass with a toggling pattern on both channels
    chop_en = '0;
    for (int k = 0; k < 12; k++) begin
      ref_in = 2'(k ^ (k >> 1));
      #1.5;
      check(chop_out[0], ref_in[0], "R2", k);
      check(chop_out[1], ref_in[1], "R2", k);
      step();
    end
    ref_in = '0;
    step();

    // R3 R4 R5 R6: sweep frequency, duty, start width
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 3; s += 2)
        for (int d = 0; d < 8; d++) begin
          int ch;
          ch = d % 2;
          load_cfg(f, d, s);
          chop_en[ch] = 1'b1;
          pulse(ch, (s + 1) * 16 + 2 * 16 * (f + 1) + 3, f, d, s,
                (d == 0) ? "R6" : "R5");
        end

    // R7: truncated phase, then a full repeat of the same shape
    load_cfg(1, 3, 0);
    chop_en = 2'b01;
    pulse(0, 16 + 5, 1, 3, 0, "R7");
    pulse(0, 16 + 40, 1, 3, 0, "R7");

    // R8: changes while a channel is enabled are ignored
    cfg_freq = 4'd0; cfg_duty = 3'd5; cfg_start = 4'd1;
    step();
    pulse(0, 16 + 70, 1, 3, 0, "R8");
    chop_en = 2'b10;
    step();
    pulse(1, 16 + 70, 1, 3, 0, "R8");
    chop_en = 2'b00;
    step();
    chop_en = 2'b01;
    pulse(0, 32 + 40, 0, 5, 1, "R8");

    // R9: both channels chopping with offset references
    load_cfg(0, 2, 0);
    chop_en = 2'b11;
    ref_in[0] = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (k == 7) ref_in[1] = 1'b1;
      #1.5;
      check(chop_out[0], model(k, 0, 2, 0), "R9", k);
      check(chop_out[1], (k >= 7) ? model(k - 7, 0, 2, 0) : 1'b0, "R9", k);
      step();
    end
    ref_in = '0;
    #0.5;
    check(chop_out[0], 1'b0, "R7", 60);
    check(chop_out[1], 1'b0, "R7", 60);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule